// File: doc/BRIEF.md
# PCM Port Mode and Power Sequencer

This block is the control side of one voice codec channel's serial PCM port. It runs on the bit clock and watches the transmit frame sync, the receive frame sync, the receive bit clock and an active-low power-down input. From these it works out which serial interface mode is in use, which B channel is active, whether the receive path must be muted, and whether the channel is powered. It then gates the tri-state enable of the transmit data pin.

A receive bit clock that toggles during a frame selects frame-sync operation. When it holds a static level for a whole frame, one of two time-division modes is selected, and the receive frame sync then acts as a B1/B2 channel select. The channel powers down from the pin or when both frame syncs stop. It powers up again on a transmit frame sync with the pin high. Transmit data stays disabled for two further frames after that. The shifting of bits is done elsewhere: a neighbour raises `tx_slot_i` while its PCM word is on the wire.

Top module: `pcm_port_seq`

## Requirements
- R1: While `pdi_i` is 0, `dt_oe_o` is 0 in that same cycle, and `powered_o` is 0 after the next clock edge. The block stays down until R3 is met.
- R2: If `fst_i` and `fsr_i` are both low for more than STALL_FRAMES*FRAME_LEN consecutive cycles, the block powers down. This happens at the edge of low cycle number STALL_FRAMES*FRAME_LEN+1. With fewer low cycles the block stays powered.
- R3: From power-down, `powered_o` rises only at a clock edge that samples a rising edge of `fst_i` with `pdi_i` high. Cycles without an FST rising edge leave the block down, even with `pdi_i` high.
- R4: After the waking FST rising edge, `dt_oe_o` stays 0 until GUARD_FRAMES further FST rising edges have been sampled. It may go high from the cycle after the last of these.
- R5: Once fully up with `pdi_i` high, `dt_oe_o` equals `tx_slot_i` in the same cycle. It is 0 outside the slot.
- R6: At each FST rising edge, `mode_o` is set from the bit clock of the frame that just ended. If any `bclkr_i` change was seen since the previous FST rising edge, including one in the cycle of the new edge, `mode_o` becomes 0 (frame-sync mode). Otherwise it becomes 1 (IDL) if `bclkr_i` is 1, or 2 (GCI) if `bclkr_i` is 0. After reset, `mode_o` is 0. Between FST rising edges it does not change.
- R7: `chan_b2_o` is `fsr_i` delayed by one cycle while the mode is 1 or 2. It is 0 in mode 0.
- R8: In mode 0, at an FST rising edge, `rx_mute_o` becomes 1 if `fsr_i` was not high in any cycle after the previous FST rising edge and is not high in the current cycle. Otherwise it becomes 0. A rising edge of `fsr_i` clears it from the next cycle.
- R9: After reset, the block is powered down with `mode_o` 0 and `rx_mute_o` 0, `chan_b2_o` 0 and `dt_oe_o` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pdi_i | input | 1 | Power-down input, 0 forces power-down |
| fst_i | input | 1 | Transmit frame sync |
| fsr_i | input | 1 | Receive frame sync, or channel select in IDL/GCI |
| bclkr_i | input | 1 | Receive bit clock, or mode strap when static |
| tx_slot_i | input | 1 | High while the serializer shifts a PCM word |
| dt_oe_o | output | 1 | Transmit data output enable |
| rx_mute_o | output | 1 | Receive path muted to mid-scale |
| chan_b2_o | output | 1 | 1 selects B2, 0 selects B1 |
| mode_o | output | 2 | 0 frame sync, 1 IDL, 2 GCI |
| powered_o | output | 1 | Channel powered (guard or up) |

## Verification
`dt_oe_o` is combinational, so it is sampled two time units after the inputs of a cycle are driven and before that cycle's edge. `powered_o`, `mode_o` and `rx_mute_o` change one edge after the FST rising edge, FSR edge or PDI level that causes them. `chan_b2_o` follows `fsr_i` one edge late, so the bench reads these outputs a few cycles into each frame, after the deciding edge. The stall timeout is checked on both sides of the edge of low cycle number STALL_FRAMES*FRAME_LEN+1. The guard window is checked in each frame by counting FST rising edges since the wake-up.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  typedef enum logic [1:0] {
    MODE_FS  = 2'd0,
    MODE_IDL = 2'd1,
    MODE_GCI = 2'd2
  } port_mode_e;

  typedef enum logic [1:0] {
    PWR_DOWN  = 2'd0,
    PWR_GUARD = 2'd1,
    PWR_UP    = 2'd2
  } pwr_state_e;
endpackage

// File: rtl/pcm_edge_reg.sv
module pcm_edge_reg #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] chg_o
);
  logic [W-1:0] q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q[i] <= 1'b0;
      else         q[i] <= d_i[i];
    end
    assign rise_o[i] = d_i[i] & ~q[i];
    assign chg_o[i]  = d_i[i] ^ q[i];
  end
endmodule

// File: rtl/pcm_stall_timer.sv
module pcm_stall_timer #(
  parameter int FRAME_LEN    = 32,
  parameter int STALL_FRAMES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_any_i,
  output logic stall_o
);
  localparam int LIMIT = FRAME_LEN * STALL_FRAMES;
  localparam int CW    = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (sync_any_i)         cnt_q <= '0;
    else if (cnt_q != CW'(LIMIT)) cnt_q <= cnt_q + CW'(1);
  end

  // a returning sync pre-empts the timeout
  assign stall_o = (cnt_q == CW'(LIMIT)) & ~sync_any_i;
endmodule

// File: rtl/pcm_mode_detect.sv
module pcm_mode_detect
  import pcm_port_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fst_rise_i,
  input  logic       bclkr_i,
  input  logic       bclkr_chg_i,
  input  logic       fsr_i,
  input  logic       fsr_rise_i,
  output port_mode_e mode_o,
  output logic       mute_o,
  output logic       chan_b2_o
);
  port_mode_e mode_q, mode_d;
  logic clk_seen_q, fsr_seen_q, mute_q, chan_q;

  always_comb begin
    mode_d = mode_q;
    if (fst_rise_i) begin
      if (clk_seen_q | bclkr_chg_i) mode_d = MODE_FS;
      else                          mode_d = bclkr_i ? MODE_IDL : MODE_GCI;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= MODE_FS;
      clk_seen_q <= 1'b0;
      fsr_seen_q <= 1'b0;
      mute_q     <= 1'b0;
      chan_q     <= 1'b0;
    end else begin
      mode_q <= mode_d;
      chan_q <= (mode_q != MODE_FS) & fsr_i;
      if (fst_rise_i) begin
        clk_seen_q <= 1'b0;
        fsr_seen_q <= 1'b0;
        mute_q     <= (mode_d == MODE_FS) & ~(fsr_seen_q | fsr_i);
      end else begin
        clk_seen_q <= clk_seen_q | bclkr_chg_i;
        fsr_seen_q <= fsr_seen_q | fsr_i;
        if (fsr_rise_i) mute_q <= 1'b0;
      end
    end
  end

  assign mode_o    = mode_q;
  assign mute_o    = mute_q;
  assign chan_b2_o = chan_q;
endmodule

// File: rtl/pcm_power_fsm.sv
module pcm_power_fsm
  import pcm_port_pkg::*;
#(
  parameter int GUARD_FRAMES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pdi_i,
  input  logic fst_rise_i,
  input  logic stall_i,
  output logic powered_o,
  output logic up_o
);
  localparam int GW = $clog2(GUARD_FRAMES + 1);

  pwr_state_e st_q, st_d;
  logic [GW-1:0] g_q, g_d;

  always_comb begin
    st_d = st_q;
    g_d  = g_q;
    unique case (st_q)
      PWR_DOWN: if (pdi_i && fst_rise_i) begin
        st_d = PWR_GUARD;
        g_d  = '0;
      end
      PWR_GUARD: if (fst_rise_i) begin
        if (g_q == GW'(GUARD_FRAMES - 1)) st_d = PWR_UP;
        else                               g_d  = g_q + GW'(1);
      end
      default: ;
    endcase
    if (!pdi_i)                          st_d = PWR_DOWN;
    else if (stall_i && st_q != PWR_DOWN) st_d = PWR_DOWN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= PWR_DOWN;
      g_q  <= '0;
    end else begin
      st_q <= st_d;
      g_q  <= g_d;
    end
  end

  assign powered_o = (st_q != PWR_DOWN);
  assign up_o      = (st_q == PWR_UP);
endmodule

// File: rtl/pcm_port_seq.sv
module pcm_port_seq
  import pcm_port_pkg::*;
#(
  parameter int FRAME_LEN    = 32,
  parameter int STALL_FRAMES = 4,
  parameter int GUARD_FRAMES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pdi_i,
  input  logic       fst_i,
  input  logic       fsr_i,
  input  logic       bclkr_i,
  input  logic       tx_slot_i,
  output logic       dt_oe_o,
  output logic       rx_mute_o,
  output logic       chan_b2_o,
  output logic [1:0] mode_o,
  output logic       powered_o
);
  logic [2:0] rise, chg;
  logic stall, up;
  port_mode_e mode;

  pcm_edge_reg #(.W(3)) u_edges (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({bclkr_i, fsr_i, fst_i}),
    .rise_o(rise),
    .chg_o (chg)
  );

  pcm_stall_timer #(.FRAME_LEN(FRAME_LEN), .STALL_FRAMES(STALL_FRAMES)) u_stall (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sync_any_i(fst_i | fsr_i),
    .stall_o   (stall)
  );

  pcm_mode_detect u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fst_rise_i (rise[0]),
    .bclkr_i    (bclkr_i),
    .bclkr_chg_i(chg[2]),
    .fsr_i      (fsr_i),
    .fsr_rise_i (rise[1]),
    .mode_o     (mode),
    .mute_o     (rx_mute_o),
    .chan_b2_o  (chan_b2_o)
  );

  pcm_power_fsm #(.GUARD_FRAMES(GUARD_FRAMES)) u_pwr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pdi_i     (pdi_i),
    .fst_rise_i(rise[0]),
    .stall_i   (stall),
    .powered_o (powered_o),
    .up_o      (up)
  );

  assign mode_o  = mode;
  assign dt_oe_o = up & pdi_i & tx_slot_i;
endmodule

// File: rtl/pcm_port_seq_chk.sv
module pcm_port_seq_chk #(
  parameter int FRAME_LEN    = 32,
  parameter int STALL_FRAMES = 4,
  parameter int GUARD_FRAMES = 2
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pdi_i,
  input logic       fst_i,
  input logic       fsr_i,
  input logic       dt_oe_o,
  input logic       rx_mute_o,
  input logic       chan_b2_o,
  input logic [1:0] mode_o,
  input logic       powered_o
);
  localparam int LIMIT = FRAME_LEN * STALL_FRAMES;
  localparam int LW    = $clog2(LIMIT + 2);
  localparam int RW    = $clog2(GUARD_FRAMES + 2);

  logic fst_q, fsr_q;
  logic [LW-1:0] low_cnt;
  logic [RW-1:0] rise_cnt;
  logic fst_rise, fsr_rise;

  assign fst_rise = fst_i & ~fst_q;
  assign fsr_rise = fsr_i & ~fsr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fst_q    <= 1'b0;
      fsr_q    <= 1'b0;
      low_cnt  <= '0;
      rise_cnt <= '0;
    end else begin
      fst_q <= fst_i;
      fsr_q <= fsr_i;
      if (fst_i | fsr_i)                  low_cnt <= '0;
      else if (low_cnt != LW'(LIMIT + 1)) low_cnt <= low_cnt + LW'(1);
      if (!powered_o)
        rise_cnt <= fst_rise ? RW'(1) : RW'(0);
      else if (fst_rise && rise_cnt != RW'(GUARD_FRAMES + 1))
        rise_cnt <= rise_cnt + RW'(1);
    end
  end

  a_r1_pdi_gates_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pdi_i |-> !dt_oe_o);
  a_r1_pdi_forces_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pdi_i |=> !powered_o);
  a_r2_stall_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(powered_o) && $past(pdi_i)) |-> (low_cnt > LW'(LIMIT)));
  a_r3_wake_needs_fst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(powered_o) |-> ($past(fst_rise) && $past(pdi_i)));
  a_r4_guard_frames: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dt_oe_o |-> (rise_cnt == RW'(GUARD_FRAMES + 1)));
  a_r6_mode_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fst_rise |=> $stable(mode_o));
  a_r7_chan_needs_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_b2_o |-> ($past(mode_o) != 2'd0));
  a_r8_fsr_unmutes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsr_rise |=> !rx_mute_o);
endmodule

bind pcm_port_seq pcm_port_seq_chk #(
  .FRAME_LEN   (FRAME_LEN),
  .STALL_FRAMES(STALL_FRAMES),
  .GUARD_FRAMES(GUARD_FRAMES)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pdi_i    (pdi_i),
  .fst_i    (fst_i),
  .fsr_i    (fsr_i),
  .dt_oe_o  (dt_oe_o),
  .rx_mute_o(rx_mute_o),
  .chan_b2_o(chan_b2_o),
  .mode_o   (mode_o),
  .powered_o(powered_o)
);

// File: tb/pcm_port_seq_bench.sv
module pcm_port_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int FL = 32;
  localparam int SF = 4;
  localparam int GF = 2;
  localparam int LIMIT = FL * SF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pdi = 1'b1, fst = 1'b0, fsr = 1'b0, bclkr = 1'b0, slot = 1'b0;
  logic dt_oe, rx_mute, chan_b2, powered;
  logic [1:0] mode;
  logic oe_now;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model
  int st_m = 0, w_m = 0, mode_m = 0, prev_b = 0;
  bit mute_m = 0, prev_after0 = 0, bl = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcm_port_seq #(.FRAME_LEN(FL), .STALL_FRAMES(SF), .GUARD_FRAMES(GF)) u_pcm_port_seq (
    .clk_i(clk), .rst_ni(rst_n), .pdi_i(pdi), .fst_i(fst), .fsr_i(fsr),
    .bclkr_i(bclkr), .tx_slot_i(slot), .dt_oe_o(dt_oe), .rx_mute_o(rx_mute),
    .chan_b2_o(chan_b2), .mode_o(mode), .powered_o(powered)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cycle(input logic f, input logic r, input logic b, input logic s);
    fst = f; fsr = r; bclkr = b; slot = s;
    #2;
    oe_now = dt_oe;
    @(posedge clk);
    #1;
  endtask

  // rk: 0 no fsr, 1 fsr at cycle 0, 2 fsr at cycle 5, 3 fsr held high
  // bk: 0 held low, 1 held high, 2 toggling
  task automatic run_frame(input int rk, input int bk);
    bit b0;
    b0 = bl;
    if (!pdi) st_m = 0;
    else if (st_m == 0) begin st_m = 1; w_m = 1; end
    else if (st_m == 1) begin w_m++; if (w_m == GF + 1) st_m = 2; end
    mode_m = (prev_b == 2) ? 0 : ((prev_b == 1) ? 1 : 2);
    mute_m = (mode_m == 0) && !prev_after0 && !(rk == 1 || rk == 3);
    for (int c = 0; c < FL; c++) begin
      logic r, b;
      r = (rk == 3) || (rk == 1 && c == 0) || (rk == 2 && c == 5);
      b = (bk == 2) ? (b0 ^ c[0]) : bk[0];
      bl = b;
      cycle(c == 0, r, b, (c >= 1 && c <= 8));
      if (c == 3) begin
        chk("R3 powered_o", powered, (st_m != 0));
        chk("R6 mode_o", mode, mode_m);
        chk("R8 rx_mute_o", rx_mute, mute_m);
        chk("R7 chan_b2_o", chan_b2, (mode_m != 0 && rk == 3));
      end
      if (c == 4) chk("R4 R5 dt_oe_o in slot", oe_now, (st_m == 2 && pdi));
      if (c == 10) chk("R5 dt_oe_o outside slot", oe_now, 0);
      if (c == 7 && rk == 2) chk("R8 fsr rise unmutes", rx_mute, 0);
    end
    prev_b = bk;
    prev_after0 = (rk == 2 || rk == 3);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cycle(0, 0, 0, 1);
    chk("R9 dt_oe_o", oe_now, 0);
    chk("R9 powered_o", powered, 0);
    chk("R9 mode_o", mode, 0);
    chk("R9 rx_mute_o", rx_mute, 0);
    chk("R9 chan_b2_o", chan_b2, 0);
    repeat (5) cycle(0, 0, 0, 0);
    chk("R3 no wake without fst", powered, 0);

    pdi = 1'b0;
    run_frame(1, 2);
    chk("R3 no wake with pdi low", powered, 0);
    pdi = 1'b1;

    // mode and mute sweep, held-level changes separated by toggling frames
    foreach (bseq[i]) ;
    for (int i = 0; i < 5; i++) begin
      int bk;
      bk = (i == 1) ? 1 : ((i == 3) ? 0 : 2);
      for (int r = 0; r < 4; r++) run_frame(r, bk);
    end
    for (int p = 0; p < 4; p++)
      for (int q = 0; q < 4; q++) begin
        run_frame(p, 2);
        run_frame(q, 2);
      end

    // stall: 31 low cycles already counted after this frame
    run_frame(1, 2);
    for (int l = FL; l <= LIMIT + 1; l++) begin
      cycle(0, 0, bl, 0);
      if (l == LIMIT) chk("R2 still up at limit", powered, 1);
      if (l == LIMIT + 1) chk("R2 down after limit", powered, 0);
    end
    st_m = 0;

    for (int k = 0; k < 4; k++) run_frame(1, 2);

    // pdi drop inside a slot
    pdi = 1'b0;
    cycle(0, 0, bl, 1);
    chk("R1 dt_oe_o same cycle", oe_now, 0);
    chk("R1 powered_o next edge", powered, 0);
    pdi = 1'b1;
    st_m = 0;
    repeat (3) cycle(0, 0, bl, 1);
    chk("R1 stays down", powered, 0);
    chk("R1 dt_oe_o stays low", oe_now, 0);
    for (int k = 0; k < 4; k++) run_frame(3, 2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  int bseq[1];
endmodule